// File: doc/BRIEF.md
# Cache-Side Permission Epoch Tracker

This block sits next to a cache controller and keeps a small table of permission intervals ("epochs") for cache blocks. An epoch runs from the moment the controller gains a permission on a block to the moment it loses it, and it is either read-only or read-write. When permission is granted, the controller presents the block address, the kind of permission and the block contents. The tracker stores the address, the kind, a timestamp and a 16-bit hash of the contents in a free slot. When permission is lost, the controller presents the address and the contents again. The tracker stamps the end time and end hash into the slot and queues a report for a memory-side verifier.

In parallel, every replayed load or store is looked up in the table. A store needs an open read-write epoch for its block. A load needs any open epoch. An access that breaks this rule raises a one-cycle error pulse that carries the address. The access path has no handshake, so checking never holds up the access. Protocol misuse raises a separate error pulse: opening an epoch on a block that already has one, opening one when the table is full, or closing one that is not open. Reports leave over a valid/ready handshake, and a slot stays occupied until its report is accepted.

Top module: `epoch_tracker`

## Requirements
- R1: After reset no report is offered and neither error output is high.
- R2: An accepted open stores the block address, the epoch kind (open_rw=1 read-write, 0 read-only), the current timestamp and the hash of open_data in the lowest free slot. A close stores the current timestamp and the hash of close_data as the epoch's end values.
- R3: From the cycle after a successful close, a report is offered that carries the address, the kind, both times and both hashes. rpt_t_end minus rpt_t_begin equals the number of clock cycles between the open and the close.
- R4: The hash is the XOR of the DATA_W/16 consecutive 16-bit slices of the block data. Slice 0 is bits 15:0.
- R5: While rpt_ready is low, an offered report stays offered with unchanged fields, and its slot cannot be reused. The slot is freed in the cycle the report is accepted.
- R6: A store is legal only in an open read-write epoch of its block. A load is legal in an open epoch of either kind. An illegal access makes acc_err high for exactly the following cycle, with acc_err_addr holding its address.
- R7: An access to a block that has no open epoch is illegal, including a block whose epoch is closed and waiting to be reported.
- R8: An open on a block that already has an open epoch, or an open when no slot is free, is refused. It raises proto_err in the following cycle and leaves the table unchanged.
- R9: A close on a block with no open epoch raises proto_err in the following cycle and produces no report.
- R10: An access presented in the same cycle as an open or close is judged against the table as it was before that cycle. It is illegal beside an open of its block and legal beside a close of its block.
- R11: Once offered, a report stays offered until accepted, even if other epochs close meanwhile. Further pending reports then go out lowest slot first.
- R12: Accesses may arrive on consecutive cycles. Each one receives its own verdict one cycle later, and none is ever refused or delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_valid | input | 1 | Permission gained this cycle |
| open_addr | input | ADDR_W | Block address of the new epoch |
| open_rw | input | 1 | 1 read-write, 0 read-only |
| open_data | input | DATA_W | Block contents at grant |
| close_valid | input | 1 | Permission lost this cycle |
| close_addr | input | ADDR_W | Block address of the ending epoch |
| close_data | input | DATA_W | Block contents at loss |
| acc_valid | input | 1 | Replayed access to check |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_store | input | 1 | 1 store, 0 load |
| rpt_valid | output | 1 | Report offered |
| rpt_ready | input | 1 | Report accepted when high with rpt_valid |
| rpt_addr | output | ADDR_W | Report block address |
| rpt_rw | output | 1 | Report epoch kind |
| rpt_t_begin | output | TIME_W | Epoch begin time |
| rpt_h_begin | output | HASH_W | Begin data hash |
| rpt_t_end | output | TIME_W | Epoch end time |
| rpt_h_end | output | HASH_W | End data hash |
| acc_err | output | 1 | Illegal access pulse |
| acc_err_addr | output | ADDR_W | Address of the last illegal access |
| proto_err | output | 1 | Protocol misuse pulse |

## Verification
The access check and the table update can fall in the same cycle. The bench provokes this in two ways. It drives a store to a block in the cycle its read-write epoch opens and expects an access error. It then drives a store in the cycle that same epoch closes and expects no error, with the report still produced. The other contested moment is a report held back while further epochs close. The bench closes two more blocks in reverse slot order under a low ready and judges the order in which the reports come out.

// File: rtl/epoch_tracker.sv
`timescale 1ns/1ps
module epoch_tracker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  parameter int HASH_W  = 16,
  parameter int TIME_W  = 16,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_valid,
  input  logic [ADDR_W-1:0] open_addr,
  input  logic              open_rw,
  input  logic [DATA_W-1:0] open_data,
  input  logic              close_valid,
  input  logic [ADDR_W-1:0] close_addr,
  input  logic [DATA_W-1:0] close_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic [ADDR_W-1:0] rpt_addr,
  output logic              rpt_rw,
  output logic [TIME_W-1:0] rpt_t_begin,
  output logic [HASH_W-1:0] rpt_h_begin,
  output logic [TIME_W-1:0] rpt_t_end,
  output logic [HASH_W-1:0] rpt_h_end,
  output logic              acc_err,
  output logic [ADDR_W-1:0] acc_err_addr,
  output logic              proto_err
);
  localparam int FOLDS = DATA_W / HASH_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] act, pend, rw, free, open_m, close_m, acc_m;
  logic [ADDR_W-1:0]  tag [ENTRIES];
  logic [TIME_W-1:0]  tb  [ENTRIES];
  logic [TIME_W-1:0]  te  [ENTRIES];
  logic [HASH_W-1:0]  hb  [ENTRIES];
  logic [HASH_W-1:0]  he  [ENTRIES];
  logic [TIME_W-1:0]  ts;
  logic [IDX_W-1:0]   free_idx, close_idx, pend_idx, sel, sel_q;
  logic               busy, open_ok, close_hit, acc_ok, fire;

  function automatic logic [HASH_W-1:0] fold(input logic [DATA_W-1:0] d);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int k = 0; k < FOLDS; k++) h ^= d[k*HASH_W +: HASH_W];
    return h;
  endfunction

  always_comb begin
    free_idx  = '0;
    close_idx = '0;
    pend_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      free[i]    = !act[i] && !pend[i];
      open_m[i]  = act[i] && (tag[i] == open_addr);
      close_m[i] = act[i] && (tag[i] == close_addr);
      acc_m[i]   = act[i] && (tag[i] == acc_addr);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free[i])    free_idx  = IDX_W'(i);
      if (close_m[i]) close_idx = IDX_W'(i);
      if (pend[i])    pend_idx  = IDX_W'(i);
    end
  end

  assign open_ok   = open_valid && !(|open_m) && (|free);
  assign close_hit = close_valid && (|close_m);
  assign acc_ok    = |(acc_m & (acc_store ? rw : {ENTRIES{1'b1}}));
  assign rpt_valid = |pend;
  assign sel       = busy ? sel_q : pend_idx;
  assign fire      = rpt_valid && rpt_ready;

  assign rpt_addr    = tag[sel];
  assign rpt_rw      = rw[sel];
  assign rpt_t_begin = tb[sel];
  assign rpt_h_begin = hb[sel];
  assign rpt_t_end   = te[sel];
  assign rpt_h_end   = he[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      pend <= '0;
      busy <= 1'b0;
      sel_q <= '0;
      ts <= '0;
      acc_err <= 1'b0;
      acc_err_addr <= '0;
      proto_err <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      acc_err <= acc_valid && !acc_ok;
      if (acc_valid && !acc_ok) acc_err_addr <= acc_addr;
      proto_err <= (open_valid && !open_ok) || (close_valid && !close_hit);
      if (open_ok) act[free_idx] <= 1'b1;
      if (close_hit) begin
        act[close_idx]  <= 1'b0;
        pend[close_idx] <= 1'b1;
      end
      if (fire) pend[sel] <= 1'b0;
      busy  <= rpt_valid && !rpt_ready;
      sel_q <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (open_ok) begin
      tag[free_idx] <= open_addr;
      rw[free_idx]  <= open_rw;
      tb[free_idx]  <= ts;
      hb[free_idx]  <= fold(open_data);
    end
    if (close_hit) begin
      te[close_idx] <= ts;
      he[close_idx] <= fold(close_data);
    end
  end

  AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_addr) && $stable(rpt_t_begin) && $stable(rpt_t_end)); // R5
  AST_ACC_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid)); // R6
  AST_PROTO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(open_valid || close_valid)); // R8
  AST_RPT_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> pend[sel] && !act[sel]); // R11
  AST_CLOSE_MAKES_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && !proto_err && $past(1'b1) && (|close_m) |=> rpt_valid); // R3

  for (genvar i = 0; i < ENTRIES; i++) begin : g_uniq
    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_pair
      AST_UNIQUE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(act[i] && act[j] && tag[i] == tag[j])); // R8
    end
  end
endmodule

// File: tb/test_epoch_tracker.sv
`timescale 1ns/1ps
module test_epoch_tracker;
  logic clk = 0, rst_n = 0;
  logic open_valid = 0, open_rw = 0, close_valid = 0, acc_valid = 0, acc_store = 0, rpt_ready = 0;
  logic [15:0] open_addr = 0, close_addr = 0, acc_addr = 0;
  logic [63:0] open_data = 0, close_data = 0;
  logic rpt_valid, rpt_rw, acc_err, proto_err;
  logic [15:0] rpt_addr, rpt_t_begin, rpt_h_begin, rpt_t_end, rpt_h_end, acc_err_addr;
  int checks = 0, fails = 0, cyc = 0, t_o = 0, t_c = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  epoch_tracker i_epoch_tracker (.*);

  function automatic logic [15:0] ref_hash(input logic [63:0] d);
    logic [15:0] h = 0;
    for (int b = 0; b < 64; b++) h[b % 16] = h[b % 16] ^ d[b];
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint a, input longint e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, a, e);
    end
  endtask

  task automatic do_open(input logic [15:0] a, input logic rw, input logic [63:0] d);
    @(negedge clk); open_valid = 1; open_addr = a; open_rw = rw; open_data = d; t_o = cyc;
    @(negedge clk); open_valid = 0;
  endtask

  task automatic do_close(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); close_valid = 1; close_addr = a; close_data = d; t_c = cyc;
    @(negedge clk); close_valid = 0;
  endtask

  task automatic do_acc(input logic [15:0] a, input logic st);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_store = st;
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic accept;
    @(negedge clk); rpt_ready = 1;
    @(negedge clk); rpt_ready = 0;
  endtask

  task automatic t_reset;
    chk(rpt_valid == 0, "R1", "rpt_valid", rpt_valid, 0);
    chk(acc_err == 0 && proto_err == 0, "R1", "errors", {acc_err, proto_err}, 0);
  endtask

  task automatic t_basic;
    logic [63:0] d1 = 64'h1234_5678_9abc_def0, d2 = 64'h0f0f_a5a5_3c3c_ffff;
    int to;
    do_open(16'h0010, 1, d1); to = t_o;
    chk(rpt_valid == 0, "R2", "no report on open", rpt_valid, 0);
    do_acc(16'h0010, 1);
    chk(acc_err == 0, "R6", "store in rw epoch", acc_err, 0);
    do_acc(16'h0010, 0);
    chk(acc_err == 0, "R6", "load in rw epoch", acc_err, 0);
    repeat (3) @(negedge clk);
    do_close(16'h0010, d2);
    chk(rpt_valid == 1, "R3", "report offered", rpt_valid, 1);
    chk(rpt_addr == 16'h0010 && rpt_rw == 1, "R2", "addr/kind", {rpt_addr, rpt_rw}, {16'h0010, 1'b1});
    chk(16'(rpt_t_end - rpt_t_begin) == 16'(t_c - to), "R3", "duration", 16'(rpt_t_end - rpt_t_begin), 16'(t_c - to));
    chk(rpt_h_begin == ref_hash(d1), "R4", "begin hash", rpt_h_begin, ref_hash(d1));
    chk(rpt_h_end == ref_hash(d2), "R2", "end hash", rpt_h_end, ref_hash(d2));
    do_acc(16'h0010, 0);
    chk(acc_err == 1, "R7", "load after close", acc_err, 1);
    repeat (3) @(negedge clk);
    chk(rpt_valid == 1 && rpt_addr == 16'h0010 && rpt_h_end == ref_hash(d2), "R5", "held while not ready", rpt_valid, 1);
    accept;
    chk(rpt_valid == 0, "R5", "freed on accept", rpt_valid, 0);
  endtask

  task automatic t_ro;
    do_open(16'h0020, 0, 64'h5);
    do_acc(16'h0020, 0);
    chk(acc_err == 0, "R6", "load in ro epoch", acc_err, 0);
    do_acc(16'h0020, 1);
    chk(acc_err == 1, "R6", "store in ro epoch", acc_err, 1);
    chk(acc_err_addr == 16'h0020, "R6", "error address", acc_err_addr, 16'h0020);
    @(negedge clk);
    chk(acc_err == 0, "R6", "pulse one cycle", acc_err, 0);
    @(negedge clk); acc_valid = 1; acc_addr = 16'h0020; acc_store = 1;
    @(negedge clk); acc_store = 0;
    chk(acc_err == 1, "R12", "b2b store 1", acc_err, 1);
    @(negedge clk); acc_store = 1;
    chk(acc_err == 0, "R12", "b2b load", acc_err, 0);
    @(negedge clk); acc_valid = 0;
    chk(acc_err == 1, "R12", "b2b store 2", acc_err, 1);
    do_close(16'h0020, 64'h5);
    chk(rpt_rw == 0, "R2", "ro kind", rpt_rw, 0);
    accept;
  endtask

  task automatic t_noepoch;
    do_acc(16'h0033, 0);
    chk(acc_err == 1 && acc_err_addr == 16'h0033, "R7", "load with no epoch", acc_err_addr, 16'h0033);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); open_valid = 1; open_addr = 16'h0040; open_rw = 1; open_data = 64'h77;
    acc_valid = 1; acc_addr = 16'h0040; acc_store = 1;
    @(negedge clk); open_valid = 0; acc_valid = 0;
    chk(acc_err == 1, "R10", "store beside open", acc_err, 1);
    @(negedge clk); close_valid = 1; close_addr = 16'h0040; close_data = 64'h88;
    acc_valid = 1; acc_addr = 16'h0040; acc_store = 1;
    @(negedge clk); close_valid = 0; acc_valid = 0;
    chk(acc_err == 0, "R10", "store beside close", acc_err, 0);
    chk(rpt_valid == 1 && rpt_addr == 16'h0040, "R10", "close still reported", rpt_addr, 16'h0040);
    accept;
  endtask

  task automatic t_proto;
    do_open(16'h0050, 1, 64'h1);
    chk(proto_err == 0, "R8", "first open", proto_err, 0);
    do_open(16'h0050, 0, 64'h2);
    chk(proto_err == 1, "R8", "double open", proto_err, 1);
    do_close(16'h0077, 64'h0);
    chk(proto_err == 1, "R9", "close inactive", proto_err, 1);
    chk(rpt_valid == 0, "R9", "no report", rpt_valid, 0);
    do_acc(16'h0050, 1);
    chk(acc_err == 0, "R8", "refused open left rw kind", acc_err, 0);
    do_close(16'h0050, 64'h1);
    chk(rpt_h_begin == ref_hash(64'h1), "R8", "begin hash kept", rpt_h_begin, ref_hash(64'h1));
    accept;
    chk(rpt_valid == 0, "R9", "single report only", rpt_valid, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) do_open(16'h00a0 + 16'(i), 1, 64'(i));
    do_open(16'h00a4, 1, 64'h4);
    chk(proto_err == 1, "R8", "open when full", proto_err, 1);
    do_close(16'h00a2, 64'h0);
    do_open(16'h00a4, 1, 64'h4);
    chk(proto_err == 1, "R5", "pending slot held", proto_err, 1);
    chk(rpt_addr == 16'h00a2, "R5", "report a2", rpt_addr, 16'h00a2);
    accept;
    do_open(16'h00a4, 1, 64'h4);
    chk(proto_err == 0, "R5", "slot reused after accept", proto_err, 0);
    do_close(16'h00a3, 64'h0);
    do_close(16'h00a1, 64'h0);
    do_close(16'h00a0, 64'h0);
    chk(rpt_addr == 16'h00a3, "R11", "first offered stays", rpt_addr, 16'h00a3);
    accept;
    chk(rpt_valid == 1 && rpt_addr == 16'h00a0, "R11", "lowest slot next", rpt_addr, 16'h00a0);
    accept;
    chk(rpt_valid == 1 && rpt_addr == 16'h00a1, "R11", "then slot 1", rpt_addr, 16'h00a1);
    accept;
    chk(rpt_valid == 0, "R11", "drained", rpt_valid, 0);
    do_close(16'h00a4, 64'h0);
    chk(rpt_addr == 16'h00a4, "R3", "reused slot report", rpt_addr, 16'h00a4);
    accept;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_ro;
    t_noepoch;
    t_same_cycle;
    t_proto;
    t_full;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule